// File: doc/BRIEF.md
# Bidirectional Overcurrent Detector with Turn-On Blanking

This block sits behind two digital comparator results taken at a half-bridge switch node. One result says the node is above the positive trip level. The other says it is below the negative trip level. The block decides whether the low-side switch is carrying too much current in either direction, and reports this on an active-low fault flag. Sensing is enabled only while the low-side switch is commanded on. After each low-side turn-on, a fixed blanking window masks the ringing that follows the edge.

A trip that outlasts the blanking window must then hold for a filter interval of consecutive cycles before it is accepted. An accepted fault drives the flag low for a guaranteed minimum time, so that a slow reader or a shutdown path can catch it. A power-good input keeps the flag inactive while the supplies are not valid. A sticky flag latches any accepted fault until a clear pulse, for use by a shutdown controller. All three intervals are parameters counted in clock cycles. At a 200 MHz clock the defaults are 40, 40 and 20 cycles, which gives 200 ns, 200 ns and 100 ns.

Top module: `ocp_detect`

## Requirements
- R1: After reset, `fault_n` is 1 and `fault_sticky` is 0.
- R2: Comparators are ignored while `lo_on` is 0. They are also ignored for the first BLANK_CYC clock edges at which `lo_on` is sampled 1 after it was 0. A low-side on time of BLANK_CYC cycles or fewer can therefore never produce a fault.
- R3: A trip is `cmp_hi` OR `cmp_lo`. Either one alone is detected, and a hand-over from one to the other without a gap counts as one continuous trip.
- R4: A trip must be sampled at FILT_CYC consecutive edges with sensing enabled before it is accepted. `fault_n` reads 0 right after the edge that accepts it, so with `lo_on` and a trip held from the start, the first low reading follows edge BLANK_CYC+FILT_CYC. The count restarts whenever both comparators are 0 or `lo_on` is 0.
- R5: After the last accepting edge, `fault_n` stays 0 for exactly STRETCH_CYC cycles. A single accepted edge gives a low pulse of exactly STRETCH_CYC cycles.
- R6: While `pwr_ok` is 0, `fault_n` is 1 in the same cycle and `fault_sticky` cannot be set. A pending stretch is dropped at the first edge that samples `pwr_ok` as 0.
- R7: `fault_sticky` becomes 1 at the edge that accepts a fault while `pwr_ok` is 1. It holds until an edge that samples `clr_sticky` as 1. If an accept and a clear fall on the same edge, the accept wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_ok | input | 1 | Supplies valid; 0 forces the fault flag inactive |
| lo_on | input | 1 | Low-side switch commanded on |
| cmp_hi | input | 1 | Switch node above the positive trip level |
| cmp_lo | input | 1 | Switch node below the negative trip level |
| clr_sticky | input | 1 | Clears the sticky flag |
| fault_n | output | 1 | Overcurrent flag, active low, stretched |
| fault_sticky | output | 1 | Latched record of an accepted fault |

## Verification
The bench builds the block with BLANK_CYC=8, FILT_CYC=5 and STRETCH_CYC=6 in place of the 40/40/20 defaults. The three values differ from one another, so an off-by-one in any single counter, or a swap between the blanking and filter lengths, shows up as a wrong cycle count. The short intervals allow many exact latency and pulse-width measurements in a short run. They also make it cheap to test on times that end right at the blanking limit, and trips that stop one cycle short of the filter length.

// File: rtl/ocp_pkg.sv
// Shared helpers for the overcurrent detector.
// Assumes counter limits are non-negative cycle counts.
package ocp_pkg;

    // Bits needed to hold values 0..n, never less than one.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ocp_blank.sv
// Low-side gating and turn-on blanking.
// Counts edges with lo_on held high; sensing opens once BLANK_CYC of them have passed.
// Assumes lo_on is already synchronous to clk.
module ocp_blank #(
    parameter int BLANK_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_on,
    output logic sense_en
);
    generate
        if (BLANK_CYC == 0) begin : g_noblank
            // No blanking: sense whenever the low side is on.
            assign sense_en = lo_on;
        end else begin : g_blank
            localparam int W = ocp_pkg::cnt_w(BLANK_CYC);
            localparam logic [W-1:0] LIM = W'(BLANK_CYC);
            logic [W-1:0] cnt_q;

            // Count on-time edges, restart at every low-side turn-off, hold at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n)                cnt_q <= '0;
                else if (!lo_on)           cnt_q <= '0;
                else if (cnt_q != LIM)     cnt_q <= cnt_q + 1'b1;
            end

            assign sense_en = lo_on && (cnt_q == LIM);
        end
    endgenerate
endmodule

// File: rtl/ocp_filter.sv
// Trip qualification filter.
// Accepts a trip once it has been seen on FILT_CYC consecutive sensing edges.
// Assumes comparator inputs are synchronous to clk.
module ocp_filter #(
    parameter int FILT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_en,
    input  logic cmp_hi,
    input  logic cmp_lo,
    output logic qual
);
    logic trip;

    // A trip in either direction counts while sensing is open.
    assign trip = sense_en && (cmp_hi || cmp_lo);

    generate
        if (FILT_CYC <= 1) begin : g_nofilt
            // No persistence needed: every trip edge is accepted.
            assign qual = trip;
        end else begin : g_filt
            localparam int W = ocp_pkg::cnt_w(FILT_CYC - 1);
            localparam logic [W-1:0] LIM = W'(FILT_CYC - 1);
            logic [W-1:0] cnt_q;

            // Count consecutive trip edges, drop to zero on any gap, hold at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n)               cnt_q <= '0;
                else if (!trip)           cnt_q <= '0;
                else if (cnt_q != LIM)    cnt_q <= cnt_q + 1'b1;
            end

            assign qual = trip && (cnt_q == LIM);
        end
    endgenerate
endmodule

// File: rtl/ocp_stretch.sv
// Minimum-width stretcher for the fault indication.
// Reloads on every accepted edge, runs down otherwise, clears when power is not good.
// Assumes STRETCH_CYC is at least 1.
module ocp_stretch #(
    parameter int STRETCH_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic qual,
    output logic active
);
    localparam int W = ocp_pkg::cnt_w(STRETCH_CYC);
    localparam logic [W-1:0] LIM = W'(STRETCH_CYC);
    logic [W-1:0] cnt_q;

    // Reload on accept, count down to zero, discard while power is not good.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!pwr_ok)        cnt_q <= '0;
        else if (qual)           cnt_q <= LIM;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/ocp_detect.sv
// Bidirectional overcurrent detector: gating, blanking, filtering and stretch.
// Produces an active-low stretched fault flag and a sticky record.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module ocp_detect #(
    parameter int BLANK_CYC   = 40,
    parameter int FILT_CYC    = 40,
    parameter int STRETCH_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic lo_on,
    input  logic cmp_hi,
    input  logic cmp_lo,
    input  logic clr_sticky,
    output logic fault_n,
    output logic fault_sticky
);
    logic sense_en;
    logic qual;
    logic active;
    logic sticky_q;

    ocp_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_on    (lo_on),
        .sense_en (sense_en)
    );

    ocp_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sense_en (sense_en),
        .cmp_hi   (cmp_hi),
        .cmp_lo   (cmp_lo),
        .qual     (qual)
    );

    ocp_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .qual   (qual),
        .active (active)
    );

    // Latch accepted faults; an accept outranks a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sticky_q <= 1'b0;
        else if (pwr_ok && qual)    sticky_q <= 1'b1;
        else if (clr_sticky)        sticky_q <= 1'b0;
    end

    assign fault_n      = !(active && pwr_ok);
    assign fault_sticky = sticky_q;
endmodule

// File: rtl/ocp_detect_chk.sv
// Property checker for ocp_detect, attached by bind.
// Window lengths are tracked with counters so no parameter sets a delay depth.
module ocp_detect_chk #(
    parameter int BLANK_CYC   = 40,
    parameter int FILT_CYC    = 40,
    parameter int STRETCH_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic lo_on,
    input logic cmp_hi,
    input logic cmp_lo,
    input logic clr_sticky,
    input logic fault_n,
    input logic fault_sticky
);
    localparam int ON_LIM = BLANK_CYC + FILT_CYC;
    localparam int OW = ocp_pkg::cnt_w(ON_LIM);
    localparam int LW = ocp_pkg::cnt_w(STRETCH_CYC);
    localparam logic [OW-1:0] ON_MAX = OW'(ON_LIM);
    localparam logic [LW-1:0] LO_MAX = LW'(STRETCH_CYC);

    logic [OW-1:0] on_run;
    logic [LW-1:0] low_run;

    // Length of the current low-side on run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !lo_on)      on_run <= '0;
        else if (on_run != ON_MAX) on_run <= on_run + 1'b1;
    end

    // Length of the current fault low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || fault_n)      low_run <= '0;
        else if (low_run != LO_MAX) low_run <= low_run + 1'b1;
    end

    // R2: a new fault needs an on run covering blanking plus filtering.
    a_r2_blank_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> (on_run == ON_MAX));

    // R3: a new fault is preceded by a comparator trip.
    a_r3_trip_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past(cmp_hi || cmp_lo));

    // R5: a fault released with power good has lasted the full stretch.
    a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_n) && pwr_ok && $past(pwr_ok)) |-> (low_run == LO_MAX));

    // R6: power not good keeps the flag inactive.
    a_r6_pwr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> fault_n);

    // R7: the sticky flag only rises alongside an active fault.
    a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_sticky) && pwr_ok) |-> !fault_n);

    // R7: a clear with the low side off always empties the sticky flag.
    a_r7_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sticky && !lo_on) |=> !fault_sticky);
endmodule

bind ocp_detect ocp_detect_chk #(
    .BLANK_CYC   (BLANK_CYC),
    .FILT_CYC    (FILT_CYC),
    .STRETCH_CYC (STRETCH_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok       (pwr_ok),
    .lo_on        (lo_on),
    .cmp_hi       (cmp_hi),
    .cmp_lo       (cmp_lo),
    .clr_sticky   (clr_sticky),
    .fault_n      (fault_n),
    .fault_sticky (fault_sticky)
);

// File: tb/sim_ocp_detect.sv
// Directed bench for ocp_detect: one task per scenario, inputs driven and outputs read at negedge.
module sim_ocp_detect;
    localparam int B = 8;
    localparam int F = 5;
    localparam int S = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic lo_on = 1'b0;
    logic cmp_hi = 1'b0;
    logic cmp_lo = 1'b0;
    logic clr_sticky = 1'b0;
    logic fault_n;
    logic fault_sticky;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ocp_detect #(.BLANK_CYC(B), .FILT_CYC(F), .STRETCH_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .lo_on(lo_on),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .clr_sticky(clr_sticky),
        .fault_n(fault_n), .fault_sticky(fault_sticky)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drop all stimulus and wait for any stretch to run out.
    task automatic idle();
        lo_on = 0; cmp_hi = 0; cmp_lo = 0; clr_sticky = 0;
        tick(B + S + 4);
    endtask

    // Count low readings over n following cycles.
    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int k = 0; k < n; k++) begin
            tick(1);
            if (!fault_n) lows++;
        end
    endtask

    task automatic t_reset();
        chk("R1", "fault_n after reset", fault_n, 1);
        chk("R1", "sticky after reset", fault_sticky, 0);
    endtask

    // Trip held from turn-on; returns the cycle of the first low reading.
    task automatic trip_from_on(input bit use_hi, input string req);
        int first = -1;
        int lows;
        lo_on = 1; cmp_hi = use_hi; cmp_lo = !use_hi;
        for (int i = 1; i <= B + F + 3; i++) begin
            tick(1);
            if (!fault_n && first < 0) first = i;
        end
        chk(req, "first low cycle", first, B + F);
        chk("R7", "sticky after accept", fault_sticky, 1);
        cmp_hi = 0; cmp_lo = 0;
        count_low(S + 3, lows);
        chk("R5", "low cycles after trip ends", lows, S - 1);
        idle();
    endtask

    task automatic t_pos_trip();  trip_from_on(1'b1, "R3_hi_R4");  endtask
    task automatic t_neg_trip();  trip_from_on(1'b0, "R3_lo_R4");  endtask

    task automatic t_blank();
        int lows;
        clr_sticky = 1; tick(1); clr_sticky = 0;
        // R2: short on time with trip throughout.
        lo_on = 1; cmp_hi = 1;
        tick(B);
        lo_on = 0;
        count_low(B + F + S, lows);
        chk("R2", "short on time lows", lows + (fault_n ? 0 : 1), 0);
        cmp_hi = 0; idle();
        // R2: trip only inside the blanking window, on time continues.
        lo_on = 1; cmp_lo = 1;
        tick(B);
        cmp_lo = 0;
        count_low(F + S + 4, lows);
        chk("R2", "blank-window trip lows", lows, 0);
        chk("R2", "sticky after ignored trips", fault_sticky, 0);
        idle();
        // R2: comparators alone with the low side off.
        cmp_hi = 1;
        count_low(B + F + 4, lows);
        chk("R2", "lows with lo_on off", lows, 0);
        idle();
    endtask

    task automatic t_filter();
        int lows;
        int first = -1;
        lo_on = 1;
        tick(B);
        // R4: bursts one cycle short of the filter.
        for (int r = 0; r < 3; r++) begin
            cmp_lo = 1; tick(F - 1);
            cmp_lo = 0; tick(1);
        end
        count_low(S, lows);
        chk("R4", "short bursts lows", lows, 0);
        // R3: hand-over from hi to lo keeps the count running.
        cmp_hi = 1;
        for (int i = 1; i <= F; i++) begin
            if (i == 3) begin cmp_hi = 0; cmp_lo = 1; end
            tick(1);
            if (!fault_n && first < 0) first = i;
        end
        chk("R3", "hand-over accept cycle", first, F);
        idle();
    endtask

    task automatic t_lo_drop();
        int first = -1;
        lo_on = 1;
        tick(B);
        cmp_hi = 1;
        tick(F - 1);
        lo_on = 0;
        tick(1);
        chk("R4", "no fault before drop", fault_n, 1);
        lo_on = 1;
        for (int i = 1; i <= B + F; i++) begin
            tick(1);
            if (!fault_n && first < 0) first = i;
        end
        chk("R2", "blanking restarts after drop", first, B + F);
        idle();
    endtask

    task automatic t_stretch();
        int lows;
        lo_on = 1;
        tick(B);
        cmp_hi = 1;
        tick(F);
        chk("R5", "single accept visible", fault_n, 0);
        cmp_hi = 0;
        count_low(S + 4, lows);
        chk("R5", "single pulse width", lows + 1, S);
        idle();
    endtask

    task automatic t_pwr();
        int lows;
        clr_sticky = 1; tick(1); clr_sticky = 0;
        pwr_ok = 0; lo_on = 1; cmp_hi = 1;
        count_low(B + F + 3, lows);
        chk("R6", "lows while power bad", lows, 0);
        chk("R6", "sticky while power bad", fault_sticky, 0);
        pwr_ok = 1; #1;
        chk("R6", "flag right after power good", fault_n, 1);
        tick(1);
        chk("R6", "fault after power good", fault_n, 0);
        pwr_ok = 0; #1;
        chk("R6", "same-cycle force", fault_n, 1);
        tick(1);
        pwr_ok = 1; lo_on = 0; cmp_hi = 0; #1;
        chk("R6", "stretch discarded", fault_n, 1);
        idle();
    endtask

    task automatic t_sticky();
        chk("R7", "sticky held after fault ends", fault_sticky, 1);
        clr_sticky = 1; tick(1); clr_sticky = 0;
        chk("R7", "sticky cleared", fault_sticky, 0);
        lo_on = 1; cmp_lo = 1;
        tick(B + F + 2);
        clr_sticky = 1; tick(1); clr_sticky = 0;
        chk("R7", "accept wins over clear", fault_sticky, 1);
        idle();
        clr_sticky = 1; tick(1); clr_sticky = 0;
        chk("R7", "final clear", fault_sticky, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_pos_trip();
        t_neg_trip();
        t_blank();
        t_filter();
        t_lo_drop();
        t_stretch();
        t_pwr();
        t_sticky();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule